// File: doc/BRIEF.md
# Reservation Station Pool with Result-Bus Wakeup

This block is a small set of waiting slots that sits in front of one execution unit in an out-of-order core. The issue stage writes an instruction into a free slot, handing over for each of its two sources either a ready value or the tag of the instruction that will produce it. Tag zero means the value is already present. The slot number, offset by a base, becomes the rename tag of the instruction's own result. The issue stage reads that tag back on the same cycle.

Every occupied slot watches one shared result bus. When the tag on the bus equals a tag the slot is waiting on, the slot copies the broadcast value and clears that tag. A slot whose two tags are both clear competes for the execution unit. The oldest competing slot is offered on a valid/ready dispatch port, so instructions leave out of program order whenever an older one is still waiting. A dispatched slot stays occupied until its own tag appears on the result bus, and is then free for the next issue.

Top module: `rs_array`

## Requirements
- R1: After reset every slot is free: `iss_free` is 1, `iss_tag` is `TAG_BASE` (slot 0) and `dsp_valid` is 0.
- R2: An issue is accepted on a clock edge where `iss_valid` and `iss_free` are both 1. It fills the lowest-numbered free slot, whose tag is `TAG_BASE` plus the slot number, and `iss_tag` shows that tag before the edge.
- R3: When all slots are occupied, `iss_free` is 0 and `iss_valid` has no effect on any slot.
- R4: A source tag of 0 means the source value is valid. A slot issued with both tags 0 is offered on the dispatch port in the cycle after the issue edge.
- R5: An occupied slot with a nonzero source tag equal to `bus_tag` while `bus_valid` is 1 takes `bus_val` as that source and clears the tag. It can be offered in the following cycle.
- R6: A source whose issued tag equals `bus_tag` while `bus_valid` is 1 on the issue edge is stored as `bus_val` with the tag cleared.
- R7: `dsp_valid` is 1 exactly when some occupied, not yet dispatched slot has both tags clear. `dsp_op`, `dsp_a`, `dsp_b` and `dsp_tag` describe the offered slot. A dispatch happens on an edge with `dsp_valid` and `dsp_ready` both 1, and a dispatched slot is never offered again.
- R8: Among several eligible slots, the one issued earliest is offered (`OLDEST_FIRST`=1). With `OLDEST_FIRST`=0 the lowest-numbered one is offered.
- R9: A dispatched slot becomes free on the edge where `bus_valid` is 1 and `bus_tag` equals its own tag. The bus is the only way a slot is freed.
- R10: While `dsp_valid` is 1 and `dsp_ready` is 0, `dsp_valid` stays 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code of the issued instruction |
| iss_a_tag | input | TAG_W | Producer tag of source A, 0 if the value is present |
| iss_a_val | input | DATA_W | Value of source A when its tag is 0 |
| iss_b_tag | input | TAG_W | Producer tag of source B, 0 if the value is present |
| iss_b_val | input | DATA_W | Value of source B when its tag is 0 |
| iss_free | output | 1 | At least one slot is free |
| iss_tag | output | TAG_W | Tag the next accepted issue will receive |
| bus_valid | input | 1 | Result bus carries a result this cycle |
| bus_tag | input | TAG_W | Tag of the broadcast result |
| bus_val | input | DATA_W | Broadcast result value |
| dsp_valid | output | 1 | A slot is offered to the execution unit |
| dsp_ready | input | 1 | The execution unit accepts the offered slot |
| dsp_op | output | OP_W | Operation code of the offered slot |
| dsp_a | output | DATA_W | Source A value of the offered slot |
| dsp_b | output | DATA_W | Source B value of the offered slot |
| dsp_tag | output | TAG_W | Result tag of the offered slot |

## Verification
A slot that misses a wakeup never raises `dsp_valid`, and a slot that captures from the wrong tag offers a wrong `dsp_a` or `dsp_b`. Both show in the cycle after the bus pulse. A broken age order shows as the wrong `dsp_tag` in the first cycle where two slots are eligible together. A lost or spurious release shows on `iss_free` and `iss_tag` one cycle after the broadcast. The reference model in the bench follows every slot, so any of these differences is caught in the cycle it first reaches a port.

// File: rtl/rs_pkg.sv
package rs_pkg;

  // Nonzero source tag matching a valid broadcast.
  function automatic logic tag_hit(input logic bv, input logic [31:0] q, input logic [31:0] t);
    return bv && (q != 32'd0) && (q == t);
  endfunction

  // Position of the single set bit of a one-hot vector (0 when empty).
  function automatic int unsigned onehot_pos(input logic [31:0] v);
    int unsigned p;
    p = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) p = i;
    end
    return p;
  endfunction

endpackage

// File: rtl/rs_alloc.sv
module rs_alloc #(
  parameter int N = 4
) (
  input  logic [N-1:0] busy_vec,
  output logic         any_free,
  output logic [N-1:0] pick_vec
);
  logic [N-1:0] free_vec;

  always_comb begin
    free_vec = ~busy_vec;
    any_free = |free_vec;
    pick_vec = free_vec & (~free_vec + N'(1));
  end
endmodule

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
#(
  parameter int OP_W   = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16,
  parameter logic [TAG_W-1:0] MY_TAG = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  logic              fire,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_a_tag,
  input  logic [DATA_W-1:0] iss_a_val,
  input  logic [TAG_W-1:0]  iss_b_tag,
  input  logic [DATA_W-1:0] iss_b_val,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_val,
  output logic              busy,
  output logic              fired,
  output logic              ready,
  output logic              retire,
  output logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] va,
  output logic [DATA_W-1:0] vb
);
  logic [TAG_W-1:0] qa, qb;
  logic hit_a, hit_b, hit_ia, hit_ib;

  always_comb begin
    hit_a  = tag_hit(bus_valid, 32'(qa), 32'(bus_tag));
    hit_b  = tag_hit(bus_valid, 32'(qb), 32'(bus_tag));
    hit_ia = tag_hit(bus_valid, 32'(iss_a_tag), 32'(bus_tag));
    hit_ib = tag_hit(bus_valid, 32'(iss_b_tag), 32'(bus_tag));
    ready  = busy && !fired && (qa == '0) && (qb == '0);
    retire = busy && fired && bus_valid && (bus_tag == MY_TAG);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      fired <= 1'b0;
      op    <= '0;
      qa    <= '0;
      qb    <= '0;
      va    <= '0;
      vb    <= '0;
    end else if (alloc) begin
      busy  <= 1'b1;
      fired <= 1'b0;
      op    <= iss_op;
      qa    <= hit_ia ? '0 : iss_a_tag;
      va    <= hit_ia ? bus_val : iss_a_val;
      qb    <= hit_ib ? '0 : iss_b_tag;
      vb    <= hit_ib ? bus_val : iss_b_val;
    end else if (busy) begin
      if (fire) fired <= 1'b1;
      if (retire) begin
        busy  <= 1'b0;
        fired <= 1'b0;
      end
      if (hit_a) begin
        qa <= '0;
        va <= bus_val;
      end
      if (hit_b) begin
        qb <= '0;
        vb <= bus_val;
      end
    end
  end
endmodule

// File: rtl/rs_pick.sv
module rs_pick #(
  parameter int N            = 4,
  parameter bit OLDEST_FIRST = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] alloc_vec,
  input  logic [N-1:0] ready_vec,
  output logic [N-1:0] grant_vec
);
  generate
    if (OLDEST_FIRST) begin : g_age
      // older[i][j] set: slot i was issued before slot j.
      logic [N-1:0] older [N];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          for (int i = 0; i < N; i++) older[i] <= '0;
        end else begin
          for (int k = 0; k < N; k++) begin
            if (alloc_vec[k]) begin
              for (int j = 0; j < N; j++) begin
                if (j != k) begin
                  older[k][j] <= 1'b0;
                  older[j][k] <= 1'b1;
                end
              end
            end
          end
        end
      end

      always_comb begin
        for (int i = 0; i < N; i++) begin
          logic blocked;
          blocked = 1'b0;
          for (int j = 0; j < N; j++) begin
            if (j != i && ready_vec[j] && older[j][i]) blocked = 1'b1;
          end
          grant_vec[i] = ready_vec[i] && !blocked;
        end
      end
    end else begin : g_low
      always_comb grant_vec = ready_vec & (~ready_vec + N'(1));
    end
  endgenerate
endmodule

// File: rtl/rs_array.sv
module rs_array
  import rs_pkg::*;
#(
  parameter int NUM_ENT      = 4,
  parameter int OP_W         = 4,
  parameter int TAG_W        = 4,
  parameter int DATA_W       = 16,
  parameter int TAG_BASE     = 1,
  parameter bit OLDEST_FIRST = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_a_tag,
  input  logic [DATA_W-1:0] iss_a_val,
  input  logic [TAG_W-1:0]  iss_b_tag,
  input  logic [DATA_W-1:0] iss_b_val,
  output logic              iss_free,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_val,
  output logic              dsp_valid,
  input  logic              dsp_ready,
  output logic [OP_W-1:0]   dsp_op,
  output logic [DATA_W-1:0] dsp_a,
  output logic [DATA_W-1:0] dsp_b,
  output logic [TAG_W-1:0]  dsp_tag
);
  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

  logic [NUM_ENT-1:0] busy_vec, fired_vec, ready_vec, retire_vec;
  logic [NUM_ENT-1:0] pick_vec, alloc_vec, grant_vec;
  logic [OP_W-1:0]    ent_op [NUM_ENT];
  logic [DATA_W-1:0]  ent_va [NUM_ENT];
  logic [DATA_W-1:0]  ent_vb [NUM_ENT];
  logic               iss_fire, dsp_fire;
  logic [IDX_W-1:0]   alloc_idx, grant_idx;

  rs_alloc #(.N(NUM_ENT)) u_alloc (
    .busy_vec (busy_vec),
    .any_free (iss_free),
    .pick_vec (pick_vec)
  );

  always_comb begin
    iss_fire  = iss_valid && iss_free;
    alloc_vec = iss_fire ? pick_vec : '0;
    alloc_idx = IDX_W'(onehot_pos(32'(pick_vec)));
    iss_tag   = TAG_W'(TAG_BASE) + TAG_W'(alloc_idx);
  end

  generate
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
      localparam logic [TAG_W-1:0] ENT_TAG = TAG_W'(TAG_BASE + g);
      rs_entry #(
        .OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .MY_TAG(ENT_TAG)
      ) u_ent (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc     (alloc_vec[g]),
        .fire      (dsp_fire && grant_vec[g]),
        .iss_op    (iss_op),
        .iss_a_tag (iss_a_tag),
        .iss_a_val (iss_a_val),
        .iss_b_tag (iss_b_tag),
        .iss_b_val (iss_b_val),
        .bus_valid (bus_valid),
        .bus_tag   (bus_tag),
        .bus_val   (bus_val),
        .busy      (busy_vec[g]),
        .fired     (fired_vec[g]),
        .ready     (ready_vec[g]),
        .retire    (retire_vec[g]),
        .op        (ent_op[g]),
        .va        (ent_va[g]),
        .vb        (ent_vb[g])
      );
    end
  endgenerate

  rs_pick #(.N(NUM_ENT), .OLDEST_FIRST(OLDEST_FIRST)) u_pick (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_vec (alloc_vec),
    .ready_vec (ready_vec),
    .grant_vec (grant_vec)
  );

  always_comb begin
    dsp_valid = |grant_vec;
    dsp_fire  = dsp_valid && dsp_ready;
    grant_idx = IDX_W'(onehot_pos(32'(grant_vec)));
    dsp_op    = ent_op[grant_idx];
    dsp_a     = ent_va[grant_idx];
    dsp_b     = ent_vb[grant_idx];
    dsp_tag   = TAG_W'(TAG_BASE) + TAG_W'(grant_idx);
  end

  logic unused_retire;
  assign unused_retire = ^retire_vec;
endmodule

// File: rtl/rs_array_chk.sv
module rs_array_chk #(
  parameter int NUM_ENT  = 4,
  parameter int TAG_W    = 4,
  parameter int TAG_BASE = 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               iss_free,
  input logic               bus_valid,
  input logic [TAG_W-1:0]   bus_tag,
  input logic               dsp_valid,
  input logic               dsp_ready,
  input logic [NUM_ENT-1:0] busy_vec,
  input logic [NUM_ENT-1:0] fired_vec,
  input logic [NUM_ENT-1:0] ready_vec,
  input logic [NUM_ENT-1:0] grant_vec
);
  // R3: the free flag drops only when every slot is occupied
  a_r3_full_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !iss_free |-> (&busy_vec));

  // R8: at most one slot offered, and only an eligible one
  a_r8_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec) && ((grant_vec & ~ready_vec) == '0));

  // R10: an unaccepted offer persists
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_valid && !dsp_ready) |=> dsp_valid);

  generate
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_slot
      localparam logic [TAG_W-1:0] ST = TAG_W'(TAG_BASE + g);

      // R9: a slot is freed only by its own broadcast after dispatch
      a_r9_release_by_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_vec[g] && !(bus_valid && bus_tag == ST && fired_vec[g])) |=> busy_vec[g]);

      // R7: an accepted offer marks the slot dispatched
      a_r7_fire_marks: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_valid && dsp_ready && grant_vec[g]) |=> (fired_vec[g] && busy_vec[g]));
    end
  endgenerate
endmodule

bind rs_array rs_array_chk #(
  .NUM_ENT(NUM_ENT), .TAG_W(TAG_W), .TAG_BASE(TAG_BASE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .iss_free  (iss_free),
  .bus_valid (bus_valid),
  .bus_tag   (bus_tag),
  .dsp_valid (dsp_valid),
  .dsp_ready (dsp_ready),
  .busy_vec  (busy_vec),
  .fired_vec (fired_vec),
  .ready_vec (ready_vec),
  .grant_vec (grant_vec)
);

// File: tb/tb_rs_array.sv
module tb_rs_array;
  localparam int NE = 4;
  localparam int TB = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        iss_valid = 1'b0;
  logic [3:0]  iss_op = '0, iss_a_tag = '0, iss_b_tag = '0;
  logic [15:0] iss_a_val = '0, iss_b_val = '0;
  logic        iss_free;
  logic [3:0]  iss_tag;
  logic        bus_valid = 1'b0;
  logic [3:0]  bus_tag = '0;
  logic [15:0] bus_val = '0;
  logic        dsp_valid;
  logic        dsp_ready = 1'b0;
  logic [3:0]  dsp_op, dsp_tag;
  logic [15:0] dsp_a, dsp_b;

  rs_array #(.NUM_ENT(NE), .OP_W(4), .TAG_W(4), .DATA_W(16), .TAG_BASE(TB),
             .OLDEST_FIRST(1'b1)) dut (.*);

  always #10ns clk = ~clk;

  int n_chk = 0, n_bad = 0;

  // Reference state
  bit          m_busy [NE];
  bit          m_fired[NE];
  logic [3:0]  m_op [NE], m_ta [NE], m_tb [NE];
  logic [15:0] m_va [NE], m_vb [NE];
  int          m_seq [NE];
  int          seq_ctr = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int m_free_idx();
    for (int i = 0; i < NE; i++) if (!m_busy[i]) return i;
    return -1;
  endfunction

  function automatic bit m_ready(input int i);
    return m_busy[i] && !m_fired[i] && m_ta[i] == 0 && m_tb[i] == 0;
  endfunction

  // R8: earliest issued eligible slot
  function automatic int m_sel();
    int s;
    s = -1;
    for (int i = 0; i < NE; i++)
      if (m_ready(i) && (s < 0 || m_seq[i] < m_seq[s])) s = i;
    return s;
  endfunction

  task automatic compare_all();
    int f, s;
    f = m_free_idx();
    s = m_sel();
    chk(iss_free === (f >= 0), "R2 R3 R9 iss_free", 32'(iss_free), 32'(f >= 0));
    if (f >= 0) chk(iss_tag === 4'(TB + f), "R2 iss_tag", 32'(iss_tag), 32'(TB + f));
    chk(dsp_valid === (s >= 0), "R4 R5 R7 dsp_valid", 32'(dsp_valid), 32'(s >= 0));
    if (s >= 0) begin
      chk(dsp_tag === 4'(TB + s), "R8 dsp_tag", 32'(dsp_tag), 32'(TB + s));
      chk(dsp_op === m_op[s], "R7 dsp_op", 32'(dsp_op), 32'(m_op[s]));
      chk(dsp_a === m_va[s], "R5 R6 dsp_a", 32'(dsp_a), 32'(m_va[s]));
      chk(dsp_b === m_vb[s], "R5 R6 dsp_b", 32'(dsp_b), 32'(m_vb[s]));
    end
  endtask

  task automatic model_edge();
    int s, f;
    bit rel [NE];
    s = m_sel();
    f = m_free_idx();
    for (int i = 0; i < NE; i++) begin
      rel[i] = m_busy[i] && m_fired[i] && bus_valid && bus_tag == 4'(TB + i);
      if (m_busy[i]) begin
        if (bus_valid && m_ta[i] != 0 && m_ta[i] == bus_tag) begin m_ta[i] = 0; m_va[i] = bus_val; end
        if (bus_valid && m_tb[i] != 0 && m_tb[i] == bus_tag) begin m_tb[i] = 0; m_vb[i] = bus_val; end
      end
    end
    if (s >= 0 && dsp_ready) m_fired[s] = 1;
    for (int i = 0; i < NE; i++) if (rel[i]) begin m_busy[i] = 0; m_fired[i] = 0; end
    if (iss_valid && f >= 0) begin
      m_busy[f] = 1; m_fired[f] = 0; m_op[f] = iss_op; m_seq[f] = seq_ctr++;
      if (bus_valid && iss_a_tag != 0 && iss_a_tag == bus_tag) begin m_ta[f] = 0; m_va[f] = bus_val; end
      else begin m_ta[f] = iss_a_tag; m_va[f] = iss_a_val; end
      if (bus_valid && iss_b_tag != 0 && iss_b_tag == bus_tag) begin m_tb[f] = 0; m_vb[f] = bus_val; end
      else begin m_tb[f] = iss_b_tag; m_vb[f] = iss_b_val; end
    end
  endtask

  task automatic step(input bit iv, input logic [3:0] op, input logic [3:0] ta, input logic [15:0] va,
                      input logic [3:0] tb, input logic [15:0] vb, input bit bv, input logic [3:0] bt,
                      input logic [15:0] bval, input bit rdy);
    iss_valid = iv; iss_op = op; iss_a_tag = ta; iss_a_val = va; iss_b_tag = tb; iss_b_val = vb;
    bus_valid = bv; bus_tag = bt; bus_val = bval; dsp_ready = rdy;
    model_edge();
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic pick_src(output logic [3:0] t, output logic [15:0] v);
    int r, k;
    r = $urandom % 8;
    v = 16'($urandom);
    t = 0;
    if (r >= 4 && r < 6) t = 4'(5 + $urandom % 4);
    else if (r >= 6) begin
      k = $urandom % NE;
      if (m_busy[k]) t = 4'(TB + k);
    end
  endtask

  task automatic rand_cycle();
    logic [3:0] ta, tb, bt;
    logic [15:0] va, vb;
    int k;
    bit bv;
    pick_src(ta, va);
    pick_src(tb, vb);
    bv = ($urandom % 10) < 7;
    bt = 4'(5 + $urandom % 4);
    if ($urandom % 2 == 0) begin
      k = $urandom % NE;
      if (m_fired[k]) bt = 4'(TB + k);
    end
    step(($urandom % 4) != 0, 4'($urandom), ta, va, tb, vb, bv, bt, 16'($urandom), ($urandom % 3) != 0);
  endtask

  initial begin
    #(20ns * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < NE; i++) begin
      m_busy[i] = 0; m_fired[i] = 0; m_ta[i] = 0; m_tb[i] = 0; m_seq[i] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(iss_free === 1'b1, "R1 iss_free", 32'(iss_free), 1);
    chk(iss_tag === 4'(TB), "R1 iss_tag", 32'(iss_tag), TB);
    chk(dsp_valid === 1'b0, "R1 dsp_valid", 32'(dsp_valid), 0);

    // slot0 tag1: A ready, B waits on 5
    step(1, 4'd3, 4'd0, 16'h0011, 4'd5, 16'h0, 0, 4'd0, 16'h0, 0);
    chk(dsp_valid === 1'b0, "R5 waiting slot not offered", 32'(dsp_valid), 0);
    chk(iss_tag === 4'd2, "R2 next tag", 32'(iss_tag), 2);
    // slot1 tag2: A tag 6 broadcast on the same edge
    step(1, 4'd4, 4'd6, 16'h0, 4'd0, 16'h0022, 1, 4'd6, 16'h0066, 0);
    chk(dsp_valid === 1'b1 && dsp_tag === 4'd2, "R6 same-edge capture offer", 32'(dsp_tag), 2);
    chk(dsp_a === 16'h0066, "R6 captured value", 32'(dsp_a), 32'h66);
    step(0, 4'd0, 4'd0, 16'h0, 4'd0, 16'h0, 0, 4'd0, 16'h0, 0);
    chk(dsp_valid === 1'b1, "R10 offer held", 32'(dsp_valid), 1);
    // wake slot0, which is older than slot1
    step(0, 4'd0, 4'd0, 16'h0, 4'd0, 16'h0, 1, 4'd5, 16'h0055, 0);
    chk(dsp_tag === 4'd1, "R8 oldest wins", 32'(dsp_tag), 1);
    chk(dsp_b === 16'h0055, "R5 wakeup value", 32'(dsp_b), 32'h55);
    step(0, 4'd0, 4'd0, 16'h0, 4'd0, 16'h0, 0, 4'd0, 16'h0, 1);
    chk(dsp_tag === 4'd2, "R7 dispatched slot not offered again", 32'(dsp_tag), 2);
    // fill the pool
    step(1, 4'd7, 4'd0, 16'h0007, 4'd0, 16'h0070, 0, 4'd0, 16'h0, 0);
    chk(dsp_tag === 4'd2, "R4 older slot still first", 32'(dsp_tag), 2);
    step(1, 4'd8, 4'd0, 16'h0008, 4'd0, 16'h0080, 0, 4'd0, 16'h0, 0);
    chk(iss_free === 1'b0, "R3 full", 32'(iss_free), 0);
    step(1, 4'd9, 4'd0, 16'h0009, 4'd0, 16'h0090, 0, 4'd0, 16'h0, 0);
    chk(iss_free === 1'b0, "R3 issue ignored when full", 32'(iss_free), 0);
    // broadcast of slot0 result frees it
    step(0, 4'd0, 4'd0, 16'h0, 4'd0, 16'h0, 1, 4'd1, 16'h1234, 0);
    chk(iss_free === 1'b1 && iss_tag === 4'd1, "R9 release", 32'(iss_tag), 1);

    for (int c = 0; c < 5000; c++) rand_cycle();

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule